// File: doc/BRIEF.md
# Loopback-Switchable CRC-32 Frame Check Unit

This block sits between a host byte stream and the line. It holds one CRC-32 engine and lends it to the transmit side or to the receive side. In normal operation, and in loopback with receive checking switched off, the engine runs over each outgoing frame and four check bytes are appended after the frame's last byte. In loopback with receive checking switched on, the host supplies frames whose last four bytes already hold their check value. Nothing is appended, and the engine runs over the looped-back copy on the receive side to verify it.

In loopback the transmit stream is routed internally to the receive side and the line stays idle in both directions. After every frame delivered to the host, a one-cycle status reports the byte count and a check-error flag. A separate output shows when the engine belongs to the receiver, so that address-hash logic next to the block knows when it can use a receive-side CRC.

Top module: `lb_fcs_unit`

## Requirements
- R1: Outside loopback, the line transmit stream carries the frame bytes unchanged, followed by four check bytes. The check value is CRC-32 with polynomial 0x04C11DB7, reflected input, initial value 0xFFFFFFFF and final inversion, sent least significant byte first. `line_tx_last` is high only on the final check byte.
- R2: Outside loopback, `rx_chk_en` has no effect on transmit: the four check bytes are still appended.
- R3: While `lb_en` is high, `line_tx_valid` stays low, the `line_rx_*` inputs are ignored, and the transmit stream is delivered to the receive host side.
- R4: In loopback with `rx_chk_en` low, the host receives the frame plus its four appended check bytes, and the status count includes them.
- R5: In loopback with `rx_chk_en` high, no check bytes are added, and the host receives exactly the bytes it sent.
- R6: In loopback with `rx_chk_en` high, `rx_stat_fcs_err` is 0 when the last four bytes are the correct check value of the bytes before them, and 1 otherwise.
- R7: `rx_stat_valid` pulses for one cycle in the cycle after `rx_out_last`. `rx_stat_count` equals the number of bytes delivered in that frame.
- R8: Outside loopback, a frame on `line_rx_*` reaches the receive host side unchanged. Its status reports `rx_stat_fcs_err` = 0, because the engine serves the transmitter.
- R9: `rx_crc_owner` is high exactly when `lb_en` and `rx_chk_en` are both high.
- R10: The CRC restarts at every frame boundary, so back-to-back frames each carry their own correct check value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lb_en | input | 1 | Loopback enable |
| rx_chk_en | input | 1 | Give the CRC engine to the receiver (effective only in loopback) |
| tx_in_valid | input | 1 | Host transmit byte valid |
| tx_in_data | input | 8 | Host transmit byte |
| tx_in_last | input | 1 | Last byte of the host transmit frame |
| line_tx_valid | output | 1 | Line transmit byte valid |
| line_tx_data | output | 8 | Line transmit byte |
| line_tx_last | output | 1 | Last byte of the line transmit frame |
| line_rx_valid | input | 1 | Line receive byte valid |
| line_rx_data | input | 8 | Line receive byte |
| line_rx_last | input | 1 | Last byte of the line receive frame |
| rx_out_valid | output | 1 | Host receive byte valid |
| rx_out_data | output | 8 | Host receive byte |
| rx_out_last | output | 1 | Last byte of the host receive frame |
| rx_stat_valid | output | 1 | Receive status strobe |
| rx_stat_count | output | CNT_W | Bytes in the completed frame |
| rx_stat_fcs_err | output | 1 | Check-value mismatch flag |
| rx_crc_owner | output | 1 | Engine currently serves the receiver |

## Verification
The checker assumes that the mode bits change only between frames. It also assumes that, after each transmit last byte, the host leaves at least four idle cycles for the appended check bytes, because the transmit input has no back-pressure. The directed tasks change `lb_en` and `rx_chk_en` only while both streams are idle. They wait well past the append window before starting the next frame, including in the back-to-back case, which uses a five-cycle gap. Line receive frames are driven only when no transmit frame is in flight.

// File: rtl/lb_fcs_pkg.sv
package lb_fcs_pkg;
   localparam int unsigned BYTE_W   = 8;
   localparam int unsigned CRC_BITS = 32;
   localparam logic [CRC_BITS-1:0] POLY_REFL   = 32'hEDB8_8320;
   localparam logic [CRC_BITS-1:0] CRC_SEED    = 32'hFFFF_FFFF;
   localparam logic [CRC_BITS-1:0] CRC_GOOD_RM = 32'hDEBB_20E3;

   typedef enum logic [0:0] {
      TXS_PASS = 1'b0,
      TXS_FCS  = 1'b1
   } tx_state_e;
endpackage

// File: rtl/lb_fcs_crc.sv
module lb_fcs_crc
   import lb_fcs_pkg::*;
#(
   parameter int unsigned CRC_W  = 32,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd,
   input  logic              fin,
   input  logic [DATA_W-1:0] din,
   output logic [CRC_W-1:0]  nxt
);
   logic [CRC_W-1:0] cur;
   logic [CRC_W-1:0] chain [DATA_W+1];

   assign chain[0] = cur;

   // one reflected shift step per input bit, least significant bit first
   for (genvar g = 0; g < DATA_W; g++) begin : g_step
      assign chain[g+1] = {1'b0, chain[g][CRC_W-1:1]}
                        ^ ((chain[g][0] ^ din[g]) ? POLY_REFL[CRC_W-1:0] : '0);
   end

   assign nxt = chain[DATA_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur <= CRC_SEED[CRC_W-1:0];
      end else if (upd) begin
         cur <= fin ? CRC_SEED[CRC_W-1:0] : nxt;
      end
   end
endmodule

// File: rtl/lb_fcs_tx.sv
module lb_fcs_tx
   import lb_fcs_pkg::*;
#(
   parameter int unsigned CRC_W  = 32,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              append_en,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_last,
   input  logic [CRC_W-1:0]  crc_nxt,
   output logic              crc_upd,
   output logic              crc_fin,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              out_last
);
   localparam int unsigned NBYTES = CRC_W / DATA_W;
   localparam int unsigned IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;
   localparam logic [IDX_W-1:0] IDX_END = IDX_W'(NBYTES - 1);

   tx_state_e         state;
   logic [IDX_W-1:0]  idx;
   logic [CRC_W-1:0]  fcs_q;
   logic [DATA_W-1:0] fcs_byte [NBYTES];

   for (genvar g = 0; g < NBYTES; g++) begin : g_fcs_lane
      assign fcs_byte[g] = fcs_q[g*DATA_W +: DATA_W];
   end

   assign crc_upd = in_valid && append_en && (state == TXS_PASS);
   assign crc_fin = in_last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= TXS_PASS;
         idx       <= '0;
         fcs_q     <= '0;
         out_valid <= 1'b0;
         out_data  <= '0;
         out_last  <= 1'b0;
      end else begin
         case (state)
            TXS_PASS: begin
               out_valid <= in_valid;
               out_last  <= in_valid && in_last && !append_en;
               if (in_valid) begin
                  out_data <= in_data;
                  if (in_last && append_en) begin
                     fcs_q <= ~crc_nxt;
                     idx   <= '0;
                     state <= TXS_FCS;
                  end
               end
            end
            TXS_FCS: begin
               out_valid <= 1'b1;
               out_data  <= fcs_byte[idx];
               out_last  <= (idx == IDX_END);
               idx       <= idx + 1'b1;
               if (idx == IDX_END) begin
                  state <= TXS_PASS;
               end
            end
            default: state <= TXS_PASS;
         endcase
      end
   end
endmodule

// File: rtl/lb_fcs_rx.sv
module lb_fcs_rx
   import lb_fcs_pkg::*;
#(
   parameter int unsigned CRC_W  = 32,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chk_en,
   input  logic              src_valid,
   input  logic [DATA_W-1:0] src_data,
   input  logic              src_last,
   input  logic [CRC_W-1:0]  crc_nxt,
   output logic              crc_upd,
   output logic              crc_fin,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              out_last,
   output logic              stat_valid,
   output logic [CNT_W-1:0]  stat_cnt,
   output logic              stat_err
);
   logic [CNT_W-1:0] cnt;
   logic             pend;
   logic [CNT_W-1:0] pend_cnt;
   logic             pend_err;

   assign crc_upd = src_valid && chk_en;
   assign crc_fin = src_last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt        <= '0;
         pend       <= 1'b0;
         pend_cnt   <= '0;
         pend_err   <= 1'b0;
         out_valid  <= 1'b0;
         out_data   <= '0;
         out_last   <= 1'b0;
         stat_valid <= 1'b0;
         stat_cnt   <= '0;
         stat_err   <= 1'b0;
      end else begin
         out_valid  <= src_valid;
         out_last   <= src_valid && src_last;
         pend       <= src_valid && src_last;
         stat_valid <= pend;
         if (src_valid) begin
            out_data <= src_data;
            if (src_last) begin
               cnt      <= '0;
               pend_cnt <= cnt + 1'b1;
               pend_err <= chk_en && (crc_nxt != CRC_GOOD_RM[CRC_W-1:0]);
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
         if (pend) begin
            stat_cnt <= pend_cnt;
            stat_err <= pend_err;
         end
      end
   end
endmodule

// File: rtl/lb_fcs_unit.sv
module lb_fcs_unit
   import lb_fcs_pkg::*;
#(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned CRC_W  = 32,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lb_en,
   input  logic              rx_chk_en,
   input  logic              tx_in_valid,
   input  logic [DATA_W-1:0] tx_in_data,
   input  logic              tx_in_last,
   output logic              line_tx_valid,
   output logic [DATA_W-1:0] line_tx_data,
   output logic              line_tx_last,
   input  logic              line_rx_valid,
   input  logic [DATA_W-1:0] line_rx_data,
   input  logic              line_rx_last,
   output logic              rx_out_valid,
   output logic [DATA_W-1:0] rx_out_data,
   output logic              rx_out_last,
   output logic              rx_stat_valid,
   output logic [CNT_W-1:0]  rx_stat_count,
   output logic              rx_stat_fcs_err,
   output logic              rx_crc_owner
);
   if (CRC_W != CRC_BITS) begin : g_bad_crc_w
      $error("lb_fcs_unit: CRC_W must be 32");
   end
   if (DATA_W != BYTE_W) begin : g_bad_data_w
      $error("lb_fcs_unit: DATA_W must be 8");
   end
   if (CNT_W < 4) begin : g_bad_cnt_w
      $error("lb_fcs_unit: CNT_W too small");
   end

   logic              rx_own;
   logic              tx_upd, tx_fin, rx_upd, rx_fin;
   logic              eng_upd, eng_fin;
   logic [DATA_W-1:0] eng_din;
   logic [CRC_W-1:0]  eng_nxt;
   logic              txo_valid, txo_last;
   logic [DATA_W-1:0] txo_data;
   logic              src_valid, src_last;
   logic [DATA_W-1:0] src_data;

   assign rx_own       = lb_en && rx_chk_en;
   assign rx_crc_owner = rx_own;

   assign src_valid = lb_en ? txo_valid : line_rx_valid;
   assign src_data  = lb_en ? txo_data  : line_rx_data;
   assign src_last  = lb_en ? txo_last  : line_rx_last;

   assign eng_upd = rx_own ? rx_upd   : tx_upd;
   assign eng_fin = rx_own ? rx_fin   : tx_fin;
   assign eng_din = rx_own ? src_data : tx_in_data;

   lb_fcs_crc #(.CRC_W(CRC_W), .DATA_W(DATA_W)) u_crc (
      .clk  (clk),
      .rst_n(rst_n),
      .upd  (eng_upd),
      .fin  (eng_fin),
      .din  (eng_din),
      .nxt  (eng_nxt)
   );

   lb_fcs_tx #(.CRC_W(CRC_W), .DATA_W(DATA_W)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .append_en(!rx_own),
      .in_valid (tx_in_valid),
      .in_data  (tx_in_data),
      .in_last  (tx_in_last),
      .crc_nxt  (eng_nxt),
      .crc_upd  (tx_upd),
      .crc_fin  (tx_fin),
      .out_valid(txo_valid),
      .out_data (txo_data),
      .out_last (txo_last)
   );

   lb_fcs_rx #(.CRC_W(CRC_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .chk_en    (rx_own),
      .src_valid (src_valid),
      .src_data  (src_data),
      .src_last  (src_last),
      .crc_nxt   (eng_nxt),
      .crc_upd   (rx_upd),
      .crc_fin   (rx_fin),
      .out_valid (rx_out_valid),
      .out_data  (rx_out_data),
      .out_last  (rx_out_last),
      .stat_valid(rx_stat_valid),
      .stat_cnt  (rx_stat_count),
      .stat_err  (rx_stat_fcs_err)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         line_tx_valid <= 1'b0;
         line_tx_data  <= '0;
         line_tx_last  <= 1'b0;
      end else begin
         line_tx_valid <= txo_valid && !lb_en;
         line_tx_last  <= txo_valid && txo_last && !lb_en;
         if (txo_valid) begin
            line_tx_data <= txo_data;
         end
      end
   end
endmodule

// File: rtl/lb_fcs_unit_chk.sv
module lb_fcs_unit_chk (
   input logic clk,
   input logic rst_n,
   input logic lb_en,
   input logic line_tx_valid,
   input logic line_tx_last,
   input logic rx_out_valid,
   input logic rx_out_last,
   input logic rx_stat_valid,
   input logic rx_stat_fcs_err
);
   p_line_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(lb_en) |-> !line_tx_valid);

   p_last_has_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
      line_tx_last |-> line_tx_valid);

   p_rx_last_has_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_out_last |-> rx_out_valid);

   p_stat_follows_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_out_valid && rx_out_last) |=> rx_stat_valid);

   p_stat_needs_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_stat_valid |-> $past(rx_out_valid && rx_out_last));

   p_stat_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_stat_valid |=> !rx_stat_valid);

   p_err_in_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_stat_fcs_err) |-> rx_stat_valid);
endmodule

bind lb_fcs_unit lb_fcs_unit_chk u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .lb_en          (lb_en),
   .line_tx_valid  (line_tx_valid),
   .line_tx_last   (line_tx_last),
   .rx_out_valid   (rx_out_valid),
   .rx_out_last    (rx_out_last),
   .rx_stat_valid  (rx_stat_valid),
   .rx_stat_fcs_err(rx_stat_fcs_err)
);

// File: tb/lb_fcs_unit_tb.sv
`timescale 1ns/100ps
module lb_fcs_unit_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       lb_en = 1'b0, rx_chk_en = 1'b0;
   logic       tx_in_valid = 1'b0, tx_in_last = 1'b0;
   logic [7:0] tx_in_data = '0;
   logic       line_rx_valid = 1'b0, line_rx_last = 1'b0;
   logic [7:0] line_rx_data = '0;
   logic       line_tx_valid, line_tx_last, rx_out_valid, rx_out_last;
   logic [7:0] line_tx_data, rx_out_data;
   logic       rx_stat_valid, rx_stat_fcs_err, rx_crc_owner;
   logic [15:0] rx_stat_count;

   int n_chk = 0, n_fail = 0;
   logic [7:0] frm [0:63];
   logic [7:0] lbuf [0:63];
   logic [7:0] rbuf [0:63];
   int l_n = 0, r_n = 0, l_last_n = 0, l_last_at = -1;
   int cyc = 0, r_last_cyc = -100, st_cyc = -100, st_seen = 0, st_cnt = 0, st_err = 0;

   always #2.5 clk = ~clk;

   lb_fcs_unit u_dut (
      .clk(clk), .rst_n(rst_n), .lb_en(lb_en), .rx_chk_en(rx_chk_en),
      .tx_in_valid(tx_in_valid), .tx_in_data(tx_in_data), .tx_in_last(tx_in_last),
      .line_tx_valid(line_tx_valid), .line_tx_data(line_tx_data), .line_tx_last(line_tx_last),
      .line_rx_valid(line_rx_valid), .line_rx_data(line_rx_data), .line_rx_last(line_rx_last),
      .rx_out_valid(rx_out_valid), .rx_out_data(rx_out_data), .rx_out_last(rx_out_last),
      .rx_stat_valid(rx_stat_valid), .rx_stat_count(rx_stat_count),
      .rx_stat_fcs_err(rx_stat_fcs_err), .rx_crc_owner(rx_crc_owner)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         cyc <= cyc + 1;
         if (line_tx_valid) begin
            lbuf[l_n] = line_tx_data;
            if (line_tx_last) begin l_last_n++; l_last_at = l_n; end
            l_n++;
         end
         if (rx_out_valid) begin
            rbuf[r_n] = rx_out_data;
            if (rx_out_last) r_last_cyc = cyc;
            r_n++;
         end
         if (rx_stat_valid) begin
            st_seen++; st_cyc = cyc; st_cnt = rx_stat_count; st_err = rx_stat_fcs_err;
         end
      end
   end

   function automatic logic [31:0] ref_fcs(input int n);
      logic [31:0] s = 32'hFFFFFFFF;
      for (int i = 0; i < n; i++) begin
         s = s ^ {24'd0, frm[i]};
         for (int b = 0; b < 8; b++) s = s[0] ? ((s >> 1) ^ 32'hEDB88320) : (s >> 1);
      end
      return ~s;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic clear_mon();
      l_n = 0; r_n = 0; l_last_n = 0; l_last_at = -1; st_seen = 0;
      r_last_cyc = -100; st_cyc = -100;
   endtask

   task automatic send_tx(input int n, input int tail);
      for (int i = 0; i < n; i++) begin
         tx_in_valid = 1'b1; tx_in_data = frm[i]; tx_in_last = (i == n - 1);
         @(negedge clk);
      end
      tx_in_valid = 1'b0; tx_in_last = 1'b0; tx_in_data = '0;
      repeat (tail) @(negedge clk);
   endtask

   task automatic load_digits();
      for (int i = 0; i < 9; i++) frm[i] = 8'h31 + 8'(i);
   endtask

   task automatic t_reset();
      check(!line_tx_valid && !rx_out_valid && !rx_stat_valid, "reset", 32'(line_tx_valid), 0);
      check(rx_crc_owner == 1'b0, "R9", 32'(rx_crc_owner), 0);
   endtask

   task automatic t_append_known();
      logic [31:0] f;
      lb_en = 0; rx_chk_en = 0; load_digits(); clear_mon(); @(negedge clk);
      send_tx(9, 12);
      f = {lbuf[12], lbuf[11], lbuf[10], lbuf[9]};
      check(l_n == 13, "R1", l_n, 13);
      check(f == 32'hCBF43926, "R1", f, 32'hCBF43926);
      check(l_last_n == 1 && l_last_at == 12, "R1", l_last_at, 12);
      check(lbuf[0] == 8'h31 && lbuf[8] == 8'h39, "R1", lbuf[8], 8'h39);
      check(r_n == 0, "R8", r_n, 0);
   endtask

   task automatic t_append_chk_outside();
      logic [31:0] f;
      lb_en = 0; rx_chk_en = 1; clear_mon();
      for (int i = 0; i < 5; i++) frm[i] = 8'hA0 ^ 8'(i * 17);
      @(negedge clk);
      check(rx_crc_owner == 1'b0, "R9", 32'(rx_crc_owner), 0);
      send_tx(5, 12);
      f = {lbuf[8], lbuf[7], lbuf[6], lbuf[5]};
      check(l_n == 9, "R2", l_n, 9);
      check(f == ref_fcs(5), "R2", f, ref_fcs(5));
   endtask

   task automatic t_single();
      logic [31:0] f;
      lb_en = 0; rx_chk_en = 0; clear_mon(); frm[0] = 8'h5A; @(negedge clk);
      send_tx(1, 12);
      f = {lbuf[4], lbuf[3], lbuf[2], lbuf[1]};
      check(l_n == 5 && l_last_at == 4, "R1", l_n, 5);
      check(f == ref_fcs(1), "R1", f, ref_fcs(1));
   endtask

   task automatic t_back_to_back();
      logic [31:0] f;
      lb_en = 0; rx_chk_en = 0; clear_mon();
      for (int i = 0; i < 6; i++) frm[i] = 8'(i * 29 + 3);
      @(negedge clk);
      send_tx(6, 5);
      for (int i = 0; i < 4; i++) frm[i] = 8'(200 - i * 7);
      send_tx(4, 12);
      f = {lbuf[17], lbuf[16], lbuf[15], lbuf[14]};
      check(l_n == 18 && l_last_n == 2, "R10", l_n, 18);
      check(f == ref_fcs(4), "R10", f, ref_fcs(4));
   endtask

   task automatic t_loop_plain();
      logic [31:0] f;
      lb_en = 1; rx_chk_en = 0; load_digits(); clear_mon(); @(negedge clk);
      check(rx_crc_owner == 1'b0, "R9", 32'(rx_crc_owner), 0);
      send_tx(9, 12);
      f = {rbuf[12], rbuf[11], rbuf[10], rbuf[9]};
      check(l_n == 0, "R3", l_n, 0);
      check(r_n == 13 && rbuf[0] == 8'h31, "R4", r_n, 13);
      check(f == 32'hCBF43926, "R4", f, 32'hCBF43926);
      check(st_seen == 1 && st_cnt == 13 && st_err == 0, "R4", st_cnt, 13);
      check(st_cyc == r_last_cyc + 1, "R7", st_cyc - r_last_cyc, 1);
   endtask

   task automatic t_loop_chk(input bit corrupt);
      logic [31:0] f;
      bit same;
      lb_en = 1; rx_chk_en = 1; load_digits(); clear_mon();
      f = ref_fcs(9);
      frm[9] = f[7:0]; frm[10] = f[15:8]; frm[11] = f[23:16]; frm[12] = f[31:24];
      if (corrupt) frm[11] = frm[11] ^ 8'h10;
      @(negedge clk);
      check(rx_crc_owner == 1'b1, "R9", 32'(rx_crc_owner), 1);
      send_tx(13, 12);
      same = 1;
      for (int i = 0; i < 13; i++) if (rbuf[i] != frm[i]) same = 0;
      check(l_n == 0, "R3", l_n, 0);
      check(r_n == 13 && same, "R5", r_n, 13);
      check(st_seen == 1 && st_cnt == 13, "R7", st_cnt, 13);
      check(st_err == int'(corrupt), "R6", st_err, int'(corrupt));
   endtask

   task automatic send_line(input int n);
      for (int i = 0; i < n; i++) begin
         line_rx_valid = 1'b1; line_rx_data = 8'(i * 13 + 7); line_rx_last = (i == n - 1);
         @(negedge clk);
      end
      line_rx_valid = 1'b0; line_rx_last = 1'b0; line_rx_data = '0;
      repeat (8) @(negedge clk);
   endtask

   task automatic t_line_rx();
      bit same;
      lb_en = 0; rx_chk_en = 1; clear_mon(); @(negedge clk);
      send_line(6);
      same = 1;
      for (int i = 0; i < 6; i++) if (rbuf[i] != 8'(i * 13 + 7)) same = 0;
      check(r_n == 6 && same, "R8", r_n, 6);
      check(st_seen == 1 && st_cnt == 6 && st_err == 0, "R8", st_err, 0);
      check(st_cyc == r_last_cyc + 1, "R7", st_cyc - r_last_cyc, 1);
   endtask

   task automatic t_line_rx_ignored();
      lb_en = 1; rx_chk_en = 0; clear_mon(); @(negedge clk);
      send_line(5);
      check(r_n == 0 && st_seen == 0, "R3", r_n, 0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_append_known();
      t_append_chk_outside();
      t_single();
      t_back_to_back();
      t_loop_plain();
      t_loop_chk(1'b0);
      t_loop_chk(1'b1);
      t_line_rx();
      t_line_rx_ignored();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(200000 * 5);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule